// File: doc/BRIEF.md
# Watchdog Timer with Restart Key

This block is a watchdog timer on a small 32-bit register bus. Software enables it and picks its timeout. While it runs, software must write a fixed key value to a restart register before an internal down counter reaches zero. If the counter expires, the block either pulses a system reset output right away, or first raises an interrupt and pulses the reset only when a second expiry follows without a restart.

The timeout is always a power of two. A 4-bit exponent `i` selects a period of 2^(BASE_EXP+i) clock cycles, with BASE_EXP set to 16 in the default build. The exponent used for the first count after enabling is held separately from the exponent used after each restart or expiry. The counter value can be read at any time, so software can see how much time is left.

Bus writes act on the rising clock edge at which `busWrEn` is high. Reads are combinational from `busAddr`. There is one write per cycle.

Top module: `wdog_top`

## Requirements
- R1: After reset, irq and sysRst are low, and the control register, the range register and the counter all read 0.
- R2: The control register is at offset 0x00. Bit 0 enables the watchdog and bit 1 selects the response mode (0 = reset only, 1 = interrupt first). It reads back those two bits, with the upper bits zero.
- R3: The range register is at offset 0x04. Bits [3:0] hold the normal exponent and bits [7:4] hold the initial exponent. It reads back all 8 bits.
- R4: A control write that sets bit 0 while the watchdog is disabled loads the counter with 2^(BASE_EXP+initial)-1 at that edge. While enabled, the counter then drops by one per cycle, and offset 0x08 reads its current value.
- R5: At an edge where the watchdog is enabled and the counter is 0, with no valid restart and no disable write, an expiry occurs and the counter reloads with 2^(BASE_EXP+normal)-1.
- R6: In mode 0, an expiry drives sysRst high for exactly 8 cycles, starting with the expiry edge.
- R7: In mode 1, an expiry with no interrupt pending sets the sticky irq output. An expiry while irq is already set drives the 8-cycle sysRst pulse.
- R8: Writing exactly 32'h00000076 to offset 0x0C while enabled reloads the counter with the normal period and clears irq. This restart takes priority over an expiry in the same cycle.
- R9: A write to 0x0C with any other value, or any write to 0x0C while disabled, leaves the counter and irq unchanged.
- R10: A control write with bit 0 clear stops the counter at its current value and clears irq. A later write that enables the watchdog reloads the initial period.
- R11: Reads of 0x0C and of unmapped offsets return 0, and writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W (8) | Byte offset of the register access |
| busWrEn | input | 1 | Write strobe, sampled at the rising edge |
| busWrData | input | DATA_W (32) | Write data |
| busRdData | output | DATA_W (32) | Read data for busAddr |
| irq | output | 1 | Sticky interrupt after the first expiry in mode 1 |
| sysRst | output | 1 | System reset pulse, 8 cycles long |

## Verification
The bench builds the block with BASE_EXP = 2, so the exponents 0 to 3 that it writes give periods of 4 to 32 cycles. Tens of thousands of cycles of random stimulus therefore cover many expiries, including back-to-back expiries in interrupt mode, expiries that fall inside a running reset pulse, and key writes that land exactly on the expiry cycle. The counter width stays at the full 32 bits, so the load and decrement paths are exercised at their real width.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Strobes from the control unit to the counter datapath
  typedef struct packed {
    logic loadInit;   // load the initial-period value
    logic loadNorm;   // load the normal-period value
    logic dec;        // count down by one
  } cntStrobe_t;

  localparam logic [7:0]  OFS_CTRL  = 8'h00;
  localparam logic [7:0]  OFS_RANGE = 8'h04;
  localparam logic [7:0]  OFS_COUNT = 8'h08;
  localparam logic [7:0]  OFS_KICK  = 8'h0C;
  localparam logic [31:0] KICK_KEY  = 32'h0000_0076;
  localparam int          EXP_VALUES = 16;

endpackage

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int BASE_EXP = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       strobe,
  input  logic [3:0]       initRange,
  input  logic [3:0]       normRange,
  output logic [CNT_W-1:0] cnt,
  output logic             cntZero
);

  localparam int TBL_N = EXP_VALUES;

  logic [CNT_W-1:0] periodTbl [TBL_N];
  logic [CNT_W-1:0] cntQ;

  // Reload values: 2^(BASE_EXP+g) - 1, so a full period spans 2^(BASE_EXP+g) cycles
  for (genvar g = 0; g < TBL_N; g++) begin : g_period
    assign periodTbl[g] = CNT_W'((64'd1 << (BASE_EXP + g)) - 64'd1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strobe.loadInit) begin
      cntQ <= periodTbl[initRange];
    end else if (strobe.loadNorm) begin
      cntQ <= periodTbl[normRange];
    end else if (strobe.dec) begin
      cntQ <= cntQ - CNT_W'(1);
    end
  end

  assign cnt     = cntQ;
  assign cntZero = (cntQ == '0);

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dec |=> cnt == $past(cnt) - CNT_W'(1)); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.dec || strobe.loadInit || strobe.loadNorm) |=> $stable(cnt)); // R10

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadInit, strobe.loadNorm, strobe.dec})); // R5

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dec |-> !cntZero); // R5

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 32,
  parameter int RST_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              cntZero,
  output cntStrobe_t        strobe,
  output logic [3:0]        initRange,
  output logic [3:0]        normRange,
  output logic              irq,
  output logic              sysRst
);

  localparam int RC_W = $clog2(RST_CYCLES + 1);

  logic             enQ, modeQ, irqQ;
  logic [7:0]       rangeQ;
  logic [RC_W-1:0]  rstCntQ;

  logic selCtrl, selRange, selCount, selKick;
  logic ctrlWr, rangeWr, kickWr;
  logic keyOk, disWr, enRise, expire, fire;

  always_comb begin
    selCtrl  = (busAddr == ADDR_W'(OFS_CTRL));
    selRange = (busAddr == ADDR_W'(OFS_RANGE));
    selCount = (busAddr == ADDR_W'(OFS_COUNT));
    selKick  = (busAddr == ADDR_W'(OFS_KICK));
    ctrlWr   = busWrEn && selCtrl;
    rangeWr  = busWrEn && selRange;
    kickWr   = busWrEn && selKick;
    keyOk    = kickWr && enQ && (busWrData == DATA_W'(KICK_KEY));
    disWr    = ctrlWr && !busWrData[0];
    enRise   = ctrlWr && busWrData[0] && !enQ;
    expire   = enQ && cntZero && !keyOk && !disWr;
    fire     = expire && (!modeQ || irqQ);
  end

  always_comb begin
    strobe.loadInit = enRise;
    strobe.loadNorm = keyOk || expire;
    strobe.dec      = enQ && !disWr && !keyOk && !expire;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ    <= 1'b0;
      modeQ  <= 1'b0;
      rangeQ <= '0;
    end else begin
      if (ctrlWr) begin
        enQ   <= busWrData[0];
        modeQ <= busWrData[1];
      end
      if (rangeWr) begin
        rangeQ <= busWrData[7:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqQ <= 1'b0;
    end else if (keyOk || disWr) begin
      irqQ <= 1'b0;
    end else if (expire && modeQ) begin
      irqQ <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstCntQ <= '0;
    end else if (fire) begin
      rstCntQ <= RC_W'(RST_CYCLES);
    end else if (rstCntQ != '0) begin
      rstCntQ <= rstCntQ - RC_W'(1);
    end
  end

  always_comb begin
    busRdData = '0;
    if (selCtrl) begin
      busRdData = DATA_W'({modeQ, enQ});
    end else if (selRange) begin
      busRdData = DATA_W'(rangeQ);
    end else if (selCount) begin
      busRdData = DATA_W'(cnt);
    end
  end

  assign initRange = rangeQ[7:4];
  assign normRange = rangeQ[3:0];
  assign irq       = irqQ;
  assign sysRst    = (rstCntQ != '0);

  AST_MODE0_RESET: assert property (@(posedge clk) disable iff (!rstN)
    expire && !modeQ |=> sysRst); // R6

  AST_IRQ_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    expire && modeQ && !irqQ |=> irq); // R7

  AST_SECOND_EXPIRY: assert property (@(posedge clk) disable iff (!rstN)
    expire && modeQ && irqQ |=> sysRst && irq); // R7

  AST_KEY_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    keyOk |=> !irq); // R8

  AST_BAD_KEY_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    kickWr && !keyOk && !expire |=> $stable(irq)); // R9

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    disWr |=> !irq); // R10

endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 32,
  parameter int BASE_EXP   = 16,
  parameter int RST_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              irq,
  output logic              sysRst
);

  cntStrobe_t       strobe;
  logic [3:0]       initRange, normRange;
  logic [CNT_W-1:0] cnt;
  logic             cntZero;

  wdog_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .cnt(cnt), .cntZero(cntZero), .strobe(strobe),
    .initRange(initRange), .normRange(normRange),
    .irq(irq), .sysRst(sysRst)
  );

  wdog_datapath #(
    .CNT_W(CNT_W), .BASE_EXP(BASE_EXP)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .initRange(initRange), .normRange(normRange),
    .cnt(cnt), .cntZero(cntZero)
  );

endmodule

// File: tb/wdog_top_bench.sv
`timescale 1ns/1ps
module wdog_top_bench;

  localparam int BASE = 2;
  localparam int RSTC = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic        we = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] rd;
  logic        irq, sysRst;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  // reference model state
  bit          mEn, mMode, mIrq;
  logic [7:0]  mRange;
  logic [31:0] mCnt;
  int          mRc;

  always #4 clk = ~clk;   // 125 MHz

  wdog_top #(.BASE_EXP(BASE), .RST_CYCLES(RSTC)) u_wdog_top (
    .clk(clk), .rstN(rstN), .busAddr(addr), .busWrEn(we), .busWrData(wd),
    .busRdData(rd), .irq(irq), .sysRst(sysRst)
  );

  function automatic logic [31:0] period(input logic [3:0] e);
    return 32'((64'd1 << (BASE + e)) - 64'd1);
  endfunction

  function automatic logic [31:0] expRd(input logic [7:0] a);
    case (a)
      8'h00:   return {30'b0, mMode, mEn};
      8'h04:   return {24'b0, mRange};
      8'h08:   return mCnt;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rdTag(input logic [7:0] a);
    case (a)
      8'h00:   return "R2";
      8'h04:   return "R3";
      8'h08:   return "R4";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // model update at each edge, compare outputs 2 ns later
  always @(posedge clk) begin
    if (!rstN) begin
      mEn = 0; mMode = 0; mIrq = 0; mRange = '0; mCnt = '0; mRc = 0;
    end else begin
      bit keyOk, ctrlW, dis, ex;
      keyOk = mEn && we && addr == 8'h0C && wd == 32'h76;
      ctrlW = we && addr == 8'h00;
      dis   = ctrlW && !wd[0];
      ex    = mEn && mCnt == 0 && !keyOk && !dis;
      if (ex && (!mMode || mIrq)) mRc = RSTC;
      else if (mRc != 0) mRc = mRc - 1;
      if (ctrlW && wd[0] && !mEn) mCnt = period(mRange[7:4]);
      else if (keyOk || ex)       mCnt = period(mRange[3:0]);
      else if (mEn && !dis)       mCnt = mCnt - 1;
      if (keyOk || dis)           mIrq = 0;
      else if (ex && mMode)       mIrq = 1;
      if (ctrlW) begin mEn = wd[0]; mMode = wd[1]; end
      if (we && addr == 8'h04) mRange = wd[7:0];
      #2;
      chk("R7 irq", {31'b0, irq}, {31'b0, mIrq});
      chk("R6 sysRst", {31'b0, sysRst}, {31'b0, (mRc != 0)});
      chk(rdTag(addr), rd, expRd(addr));
    end
  end

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    addr = a; wd = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rdAt(input logic [7:0] a, output logic [31:0] v);
    addr = a; #1; v = rd;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: run did not finish");
      summary();
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    rdAt(8'h00, v); chk("R1 ctrl", v, 0);
    rdAt(8'h04, v); chk("R1 range", v, 0);
    rdAt(8'h08, v); chk("R1 count", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 sysRst", {31'b0, sysRst}, 0);

    // R3: range fields (initial=2 -> 15, normal=3 -> 31)
    busWrite(8'h04, 32'h23);
    rdAt(8'h04, v); chk("R3 range readback", v, 32'h23);

    // R4: enable in mode 0 loads initial period
    busWrite(8'h00, 32'h1);
    rdAt(8'h08, v); chk("R4 initial load", v, 15);
    rdAt(8'h00, v); chk("R2 ctrl readback", v, 1);
    repeat (15) @(negedge clk);
    rdAt(8'h08, v); chk("R4 count to zero", v, 0);
    chk("R6 no reset before expiry", {31'b0, sysRst}, 0);
    @(negedge clk);
    rdAt(8'h08, v); chk("R5 reload normal", v, 31);
    chk("R6 reset starts", {31'b0, sysRst}, 1);
    repeat (7) @(negedge clk);
    chk("R6 reset 8th cycle", {31'b0, sysRst}, 1);
    @(negedge clk);
    chk("R6 reset ends", {31'b0, sysRst}, 0);
    rdAt(8'h08, v); chk("R5 counting after reload", v, 23);

    // R9: wrong key ignored; R8: right key reloads
    busWrite(8'h0C, 32'h77);
    rdAt(8'h08, v); chk("R9 bad key", v, 22);
    busWrite(8'h0C, 32'h76);
    rdAt(8'h08, v); chk("R8 key reload", v, 31);

    // R10: disable holds counter
    busWrite(8'h00, 32'h0);
    rdAt(8'h08, v); chk("R10 hold", v, 31);
    repeat (5) @(negedge clk);
    rdAt(8'h08, v); chk("R10 still held", v, 31);
    busWrite(8'h0C, 32'h76);
    rdAt(8'h08, v); chk("R9 key while disabled", v, 31);

    // R7: interrupt mode
    busWrite(8'h00, 32'h3);
    rdAt(8'h08, v); chk("R10 re-enable loads initial", v, 15);
    repeat (16) @(negedge clk);
    chk("R7 first expiry irq", {31'b0, irq}, 1);
    chk("R7 first expiry no reset", {31'b0, sysRst}, 0);
    repeat (32) @(negedge clk);
    chk("R7 second expiry reset", {31'b0, sysRst}, 1);
    busWrite(8'h0C, 32'h76);
    chk("R8 key clears irq", {31'b0, irq}, 0);

    // R11: unmapped and write-only offsets
    rdAt(8'h0C, v); chk("R11 kick reads zero", v, 0);
    busWrite(8'h10, 32'hFFFF_FFFF);
    rdAt(8'h10, v); chk("R11 unmapped read", v, 0);
    rdAt(8'h00, v); chk("R11 ctrl untouched", v, 3);
    rdAt(8'h04, v); chk("R11 range untouched", v, 32'h23);

    // random phase
    for (int i = 0; i < 30000; i++) begin
      int r;
      logic [7:0] ra;
      r = $urandom_range(0, 99);
      we = 1'b0;
      if (r < 5) begin
        addr = 8'h00; wd = {30'b0, 1'($urandom_range(0, 1)), ($urandom_range(0, 99) < 85)}; we = 1'b1;
      end else if (r < 9) begin
        addr = 8'h04; wd = {24'b0, 4'($urandom_range(0, 3)), 4'($urandom_range(0, 3))}; we = 1'b1;
      end else if (r < 12) begin
        addr = 8'h0C; wd = 32'h76; we = 1'b1;
      end else if (r < 14) begin
        addr = 8'h0C; wd = $urandom(); we = 1'b1;
      end else if (r < 16) begin
        addr = ($urandom_range(0, 1) == 0) ? 8'h08 : 8'h14; wd = $urandom(); we = 1'b1;
      end else begin
        case ($urandom_range(0, 4))
          0: ra = 8'h00; 1: ra = 8'h04; 2: ra = 8'h08; 3: ra = 8'h0C; default: ra = 8'h10;
        endcase
        addr = ra;
      end
      @(negedge clk);
    end
    we = 1'b0;
    @(negedge clk);
    done = 1'b1;
    summary();
  end

endmodule